// File: doc/BRIEF.md
# FIFO-Fed SPI Master Shift Engine

This block is the serial core of an SPI master. Software or a local sequencer loads words into an eight-entry transmit queue. Each queued word carries a flag that marks it as the final word of a transfer. A one-cycle start pulse sets the engine shifting. It moves word after word onto the serial data output and gathers the returned bits into an eight-entry receive queue. It stops once the flagged word has gone out.

Word length (4 to 24 bits), bit order, clock polarity, clock phase and an internal loopback path are plain configuration inputs. They must be held steady while a transfer runs. A five-bit event register records completion, transmit starvation, receive loss and the two queue requests. Each event has a mask bit and a write-one-to-clear input, and the unmasked pending events are ORed onto a single interrupt line. When the transmit queue runs dry before the flagged word, shifting pauses with the clock parked at its idle level. A further start pulse resumes the transfer from the next queued word.

Top module: `spi_fifo_master`

## Requirements
- R1: The effective word length is `cfg_word_len` clamped to the range 4..24. Exactly that many SCLK cycles are produced per word. Each received word appears on `rx_data` right-justified, with bits at and above the word length zero.
- R2: With `cfg_lsb_first`=1, bit 0 of each word is shifted first, in both directions. With 0, bit (length-1) is shifted first.
- R3: SCLK rests at `cfg_cpol` whenever no word is being shifted. With `cfg_cpha`=0, MOSI is valid before the first edge of a bit and MISO is sampled on its leading edge. With `cfg_cpha`=1, MOSI changes on the leading edge and MISO is sampled on the trailing edge.
- R4: A start pulse while enabled begins shifting queued words back to back. After the word whose last flag is set has been shifted, the engine stops and event bit 0 (done) is set.
- R5: If a word without the last flag completes and the transmit queue is empty, or a start arrives with an empty queue, event bit 1 (underflow) is set and the engine pauses. The next start resumes with the next queued word.
- R6: If a word completes while the receive queue is full, event bit 2 (overflow) is set and the word is dropped. The queued words are kept.
- R7: Both queues hold 8 entries and present their oldest entry without a pop. A push into a full queue and a pop from an empty queue are ignored. `tx_full` and `rx_empty` report the queue states.
- R8: A pulse on `cmd_clr_tx` or `cmd_clr_rx` makes the matching busy flag read 1 in the following cycle. The flag then drops to 0, and the queue is empty from that point. Pushes during the busy cycle are ignored.
- R9: `dev_ready` follows `cfg_enable` one cycle later. While disabled the engine is held idle and start pulses are ignored.
- R10: With `cfg_loopback`=1, the receive path samples the engine's own MOSI and ignores `miso`.
- R11: Event bits are set by their conditions and cleared by a 1 on the matching `evt_clear` bit, with setting taking priority. Bit 3 is set while the transmit queue is not full. Bit 4 is set while the receive queue is not empty.
- R12: `irq` is 1 exactly when some event bit is pending and its `evt_mask` bit is 0. A mask bit of 1 suppresses that event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_enable | input | 1 | Device enable |
| cfg_word_len | input | 5 | Bits per word, clamped to 4..24 |
| cfg_lsb_first | input | 1 | 1: least significant bit first |
| cfg_cpha | input | 1 | Clock phase select |
| cfg_cpol | input | 1 | Clock idle level |
| cfg_loopback | input | 1 | Feed MOSI back to the receiver |
| cmd_start | input | 1 | Start or resume pulse |
| cmd_clr_tx | input | 1 | Clear transmit queue pulse |
| cmd_clr_rx | input | 1 | Clear receive queue pulse |
| tx_push | input | 1 | Write a word into the transmit queue |
| tx_data | input | 24 | Word to transmit |
| tx_last | input | 1 | Marks the final word of a transfer |
| tx_full | output | 1 | Transmit queue full |
| rx_pop | input | 1 | Remove the oldest received word |
| rx_data | output | 24 | Oldest received word |
| rx_empty | output | 1 | Receive queue empty |
| dev_ready | output | 1 | Engine enabled and ready |
| tx_clr_busy | output | 1 | Transmit clear in progress |
| rx_clr_busy | output | 1 | Receive clear in progress |
| evt_mask | input | 5 | Event mask, 1 = masked |
| evt_clear | input | 5 | Write-one-to-clear for events |
| evt_pending | output | 5 | Pending events {rxreq, txreq, overflow, underflow, done} |
| irq | output | 1 | Interrupt |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |

## Verification
Event bits and queue states change at the clock edge that ends the last trailing SCLK edge of a word. They are therefore read at the falling clock edge right after it, by polling for the done or underflow bit with a timeout. `dev_ready` and the clear-busy flags are due exactly one edge after their input pulse, and the busy flag must be gone one edge later. The bench samples these at consecutive falling edges. A behavioural slave in the bench captures MOSI on the edge selected by polarity and phase, and it drives MISO from a response word. This allows bit count, bit order and received values to be computed arithmetically for every length, mode and order.

// File: rtl/spim_pkg.sv
package spim_pkg;

    localparam int DATA_W  = 24;
    localparam int LEN_W   = 5;
    localparam int MIN_LEN = 4;
    localparam int MAX_LEN = 24;
    localparam int EV_N    = 5;
    localparam int Q_DEPTH = 8;

    // event bit positions
    localparam int EV_DONE  = 0;
    localparam int EV_TXUF  = 1;
    localparam int EV_RXOF  = 2;
    localparam int EV_TXREQ = 3;
    localparam int EV_RXREQ = 4;

    typedef struct packed {
        logic              last;
        logic [DATA_W-1:0] data;
    } tx_entry_t;

    localparam int TXE_W = $bits(tx_entry_t);

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SHIFT = 2'd1,
        ST_PAUSE = 2'd2
    } eng_state_t;

    function automatic logic [LEN_W-1:0] clamp_len(input logic [LEN_W-1:0] l);
        if (l < LEN_W'(MIN_LEN))
            return LEN_W'(MIN_LEN);
        else if (l > LEN_W'(MAX_LEN))
            return LEN_W'(MAX_LEN);
        else
            return l;
    endfunction

    // wire position of the idx-th bit on the line
    function automatic logic [LEN_W-1:0] bit_pos(input logic [LEN_W-1:0] len,
                                                 input logic [LEN_W-1:0] idx,
                                                 input logic lsb);
        return lsb ? idx : (len - idx - LEN_W'(1));
    endfunction

endpackage

// File: rtl/spim_fifo.sv
module spim_fifo #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             flush,
    input  logic             push,
    input  logic [WIDTH-1:0] wdata,
    input  logic             pop,
    output logic [WIDTH-1:0] rdata,
    output logic             full,
    output logic             empty
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [AW-1:0] PTR_LAST = AW'(DEPTH - 1);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wp, rp;
    logic [CW-1:0]    cnt;
    logic             do_push, do_pop;

    assign full    = (cnt == CW'(DEPTH));
    assign empty   = (cnt == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign rdata   = mem[rp];

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (do_push)
                wp <= (wp == PTR_LAST) ? '0 : wp + AW'(1);
            if (do_pop)
                rp <= (rp == PTR_LAST) ? '0 : rp + AW'(1);
            cnt <= cnt + CW'(do_push) - CW'(do_pop);
        end
    end

    always_ff @(posedge clk) begin
        if (do_push && !flush)
            mem[wp] <= wdata;
    end

    a_r7_count_bound: assert property (@(posedge clk) disable iff (rst)
        cnt <= CW'(DEPTH));

    a_r7_full_push_ignored: assert property (@(posedge clk) disable iff (rst)
        (full && push && !pop && !flush) |=> full);

endmodule

// File: rtl/spim_events.sv
module spim_events
    import spim_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic [EV_N-1:0] set_ev,
    input  logic [EV_N-1:0] clr_ev,
    input  logic [EV_N-1:0] mask,
    output logic [EV_N-1:0] pending,
    output logic            irq
);
    for (genvar i = 0; i < EV_N; i++) begin : g_ev
        always_ff @(posedge clk) begin
            if (rst)
                pending[i] <= 1'b0;
            else if (set_ev[i])
                pending[i] <= 1'b1;
            else if (clr_ev[i])
                pending[i] <= 1'b0;
        end

        a_r11_set_wins: assert property (@(posedge clk) disable iff (rst)
            set_ev[i] |=> pending[i]);

        a_r11_w1c: assert property (@(posedge clk) disable iff (rst)
            (clr_ev[i] && !set_ev[i]) |=> !pending[i]);
    end

    assign irq = |(pending & ~mask);

endmodule

// File: rtl/spim_engine.sv
module spim_engine
    import spim_pkg::*;
#(
    parameter int HALF_DIV = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              enable,
    input  logic [LEN_W-1:0]  word_len,
    input  logic              lsb_first,
    input  logic              cpha,
    input  logic              cpol,
    input  logic              loopback,
    input  logic              start,
    input  logic              tx_empty,
    input  tx_entry_t         tx_head,
    output logic              tx_pop,
    output logic              rx_push,
    output logic [DATA_W-1:0] rx_word,
    input  logic              miso,
    output logic              sclk,
    output logic              mosi,
    output logic              ev_done,
    output logic              ev_underflow
);
    localparam int DIV_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(HALF_DIV - 1);

    eng_state_t        state;
    logic [DIV_W-1:0]  div_cnt;
    logic              phase;      // 0: before leading edge of a bit
    logic [LEN_W-1:0]  bit_idx;
    logic [DATA_W-1:0] tx_word;
    logic              tx_last;
    logic [DATA_W-1:0] rx_acc;
    logic              mosi_q;

    logic              active, tick, lead, trail, sample_now, in_bit;
    logic              word_end, idle_start, load;
    logic [LEN_W-1:0]  cur_pos, next_pos, first_pos;
    logic [DATA_W-1:0] acc_next;

    always_comb begin
        active     = enable && !rst;
        tick       = active && (state == ST_SHIFT) && (div_cnt == DIV_LAST);
        lead       = tick && !phase;
        trail      = tick && phase;
        sample_now = cpha ? trail : lead;
        in_bit     = loopback ? mosi_q : miso;
        cur_pos    = bit_pos(word_len, bit_idx, lsb_first);
        next_pos   = bit_pos(word_len, bit_idx + LEN_W'(1), lsb_first);
        first_pos  = bit_pos(word_len, '0, lsb_first);
        acc_next   = rx_acc;
        if (sample_now)
            acc_next[cur_pos] = in_bit;
        word_end   = trail && (bit_idx == word_len - LEN_W'(1));
        idle_start = active && (state != ST_SHIFT) && start;
        load       = (idle_start && !tx_empty) ||
                     (word_end && !tx_last && !tx_empty);
    end

    assign tx_pop       = load;
    assign rx_push      = word_end;
    assign rx_word      = acc_next;
    assign ev_done      = word_end && tx_last;
    assign ev_underflow = (word_end && !tx_last && tx_empty) ||
                          (idle_start && tx_empty);
    assign sclk         = cpol ^ phase;
    assign mosi         = mosi_q;

    always_ff @(posedge clk) begin
        if (rst || !enable) begin
            state   <= ST_IDLE;
            div_cnt <= '0;
            phase   <= 1'b0;
            bit_idx <= '0;
            tx_word <= '0;
            tx_last <= 1'b0;
            rx_acc  <= '0;
            mosi_q  <= 1'b0;
        end else if (load) begin
            state   <= ST_SHIFT;
            div_cnt <= '0;
            phase   <= 1'b0;
            bit_idx <= '0;
            tx_word <= tx_head.data;
            tx_last <= tx_head.last;
            rx_acc  <= '0;
            mosi_q  <= tx_head.data[first_pos];
        end else if (word_end) begin
            state   <= tx_last ? ST_IDLE : ST_PAUSE;
            div_cnt <= '0;
            phase   <= 1'b0;
            rx_acc  <= '0;
        end else if (idle_start) begin
            state   <= ST_PAUSE;
        end else if (state == ST_SHIFT) begin
            if (tick) begin
                div_cnt <= '0;
                phase   <= ~phase;
                rx_acc  <= acc_next;
                if (!phase) begin
                    if (cpha)
                        mosi_q <= tx_word[cur_pos];
                end else begin
                    bit_idx <= bit_idx + LEN_W'(1);
                    if (!cpha)
                        mosi_q <= tx_word[next_pos];
                end
            end else begin
                div_cnt <= div_cnt + DIV_W'(1);
            end
        end
    end

    a_r3_idle_level: assert property (@(posedge clk) disable iff (rst)
        (state != ST_SHIFT) |-> (sclk == cpol));

    a_r4_done_to_idle: assert property (@(posedge clk) disable iff (rst)
        (ev_done && enable) |=> (state == ST_IDLE));

    a_r5_underflow_pause: assert property (@(posedge clk) disable iff (rst)
        (ev_underflow && enable) |=> (state == ST_PAUSE));

    a_r9_disabled_idle: assert property (@(posedge clk) disable iff (rst)
        !enable |=> (state == ST_IDLE));

endmodule

// File: rtl/spi_fifo_master.sv
module spi_fifo_master
    import spim_pkg::*;
#(
    parameter int HALF_DIV = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_enable,
    input  logic [LEN_W-1:0]  cfg_word_len,
    input  logic              cfg_lsb_first,
    input  logic              cfg_cpha,
    input  logic              cfg_cpol,
    input  logic              cfg_loopback,
    input  logic              cmd_start,
    input  logic              cmd_clr_tx,
    input  logic              cmd_clr_rx,
    input  logic              tx_push,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              tx_last,
    output logic              tx_full,
    input  logic              rx_pop,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_empty,
    output logic              dev_ready,
    output logic              tx_clr_busy,
    output logic              rx_clr_busy,
    input  logic [EV_N-1:0]   evt_mask,
    input  logic [EV_N-1:0]   evt_clear,
    output logic [EV_N-1:0]   evt_pending,
    output logic              irq,
    output logic              sclk,
    output logic              mosi,
    input  logic              miso
);
    logic [LEN_W-1:0]  eff_len;
    logic              tx_empty_w, tx_pop_w, rx_push_w, rx_full_w;
    logic              uf_w, done_w, ovf_w;
    logic [DATA_W-1:0] rx_word_w;
    tx_entry_t         tx_in, tx_head;
    logic [TXE_W-1:0]  tx_head_raw;
    logic [EV_N-1:0]   ev_set;

    assign eff_len = clamp_len(cfg_word_len);

    always_ff @(posedge clk) begin
        if (rst) begin
            dev_ready   <= 1'b0;
            tx_clr_busy <= 1'b0;
            rx_clr_busy <= 1'b0;
        end else begin
            dev_ready   <= cfg_enable;
            tx_clr_busy <= cmd_clr_tx && !tx_clr_busy;
            rx_clr_busy <= cmd_clr_rx && !rx_clr_busy;
        end
    end

    assign tx_in   = '{last: tx_last, data: tx_data};
    assign tx_head = tx_entry_t'(tx_head_raw);

    spim_fifo #(.WIDTH(TXE_W), .DEPTH(Q_DEPTH)) u_txq (
        .clk   (clk),
        .rst   (rst),
        .flush (tx_clr_busy),
        .push  (tx_push && !tx_clr_busy),
        .wdata (tx_in),
        .pop   (tx_pop_w),
        .rdata (tx_head_raw),
        .full  (tx_full),
        .empty (tx_empty_w)
    );

    spim_fifo #(.WIDTH(DATA_W), .DEPTH(Q_DEPTH)) u_rxq (
        .clk   (clk),
        .rst   (rst),
        .flush (rx_clr_busy),
        .push  (rx_push_w && !rx_clr_busy),
        .wdata (rx_word_w),
        .pop   (rx_pop),
        .rdata (rx_data),
        .full  (rx_full_w),
        .empty (rx_empty)
    );

    spim_engine #(.HALF_DIV(HALF_DIV)) u_eng (
        .clk          (clk),
        .rst          (rst),
        .enable       (cfg_enable),
        .word_len     (eff_len),
        .lsb_first    (cfg_lsb_first),
        .cpha         (cfg_cpha),
        .cpol         (cfg_cpol),
        .loopback     (cfg_loopback),
        .start        (cmd_start),
        .tx_empty     (tx_empty_w),
        .tx_head      (tx_head),
        .tx_pop       (tx_pop_w),
        .rx_push      (rx_push_w),
        .rx_word      (rx_word_w),
        .miso         (miso),
        .sclk         (sclk),
        .mosi         (mosi),
        .ev_done      (done_w),
        .ev_underflow (uf_w)
    );

    assign ovf_w = rx_push_w && rx_full_w && !rx_clr_busy;

    always_comb begin
        ev_set           = '0;
        ev_set[EV_DONE]  = done_w;
        ev_set[EV_TXUF]  = uf_w;
        ev_set[EV_RXOF]  = ovf_w;
        ev_set[EV_TXREQ] = !tx_full;
        ev_set[EV_RXREQ] = !rx_empty;
    end

    spim_events u_evt (
        .clk     (clk),
        .rst     (rst),
        .set_ev  (ev_set),
        .clr_ev  (evt_clear),
        .mask    (evt_mask),
        .pending (evt_pending),
        .irq     (irq)
    );

    a_r8_clear_busy_one_cycle: assert property (@(posedge clk) disable iff (rst)
        tx_clr_busy |=> !tx_clr_busy);

    a_r8_tx_flush_empty: assert property (@(posedge clk) disable iff (rst)
        tx_clr_busy |=> tx_empty_w);

    a_r8_rx_flush_empty: assert property (@(posedge clk) disable iff (rst)
        rx_clr_busy |=> rx_empty);

    a_r9_ready_follows: assert property (@(posedge clk) disable iff (rst)
        $rose(cfg_enable) |=> dev_ready);

    a_r6_overflow_flag: assert property (@(posedge clk) disable iff (rst)
        (rx_push_w && rx_full_w && !rx_clr_busy) |=> evt_pending[EV_RXOF]);

endmodule

// File: tb/spi_fifo_master_tb_top.sv
`timescale 1ns/1ps
module spi_fifo_master_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_enable = 1'b0;
    logic [4:0]  cfg_word_len = 5'd8;
    logic        cfg_lsb_first = 1'b0;
    logic        cfg_cpha = 1'b0;
    logic        cfg_cpol = 1'b0;
    logic        cfg_loopback = 1'b0;
    logic        cmd_start = 1'b0;
    logic        cmd_clr_tx = 1'b0;
    logic        cmd_clr_rx = 1'b0;
    logic        tx_push = 1'b0;
    logic [23:0] tx_data = '0;
    logic        tx_last = 1'b0;
    logic        tx_full;
    logic        rx_pop = 1'b0;
    logic [23:0] rx_data;
    logic        rx_empty;
    logic        dev_ready;
    logic        tx_clr_busy;
    logic        rx_clr_busy;
    logic [4:0]  evt_mask = 5'h1f;
    logic [4:0]  evt_clear = '0;
    logic [4:0]  evt_pending;
    logic        irq;
    logic        sclk;
    logic        mosi;
    logic        miso;

    int n_chk = 0;
    int n_err = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    spi_fifo_master dut_i (
        .clk(clk), .rst(rst), .cfg_enable(cfg_enable), .cfg_word_len(cfg_word_len),
        .cfg_lsb_first(cfg_lsb_first), .cfg_cpha(cfg_cpha), .cfg_cpol(cfg_cpol),
        .cfg_loopback(cfg_loopback), .cmd_start(cmd_start), .cmd_clr_tx(cmd_clr_tx),
        .cmd_clr_rx(cmd_clr_rx), .tx_push(tx_push), .tx_data(tx_data), .tx_last(tx_last),
        .tx_full(tx_full), .rx_pop(rx_pop), .rx_data(rx_data), .rx_empty(rx_empty),
        .dev_ready(dev_ready), .tx_clr_busy(tx_clr_busy), .rx_clr_busy(rx_clr_busy),
        .evt_mask(evt_mask), .evt_clear(evt_clear), .evt_pending(evt_pending), .irq(irq),
        .sclk(sclk), .mosi(mosi), .miso(miso)
    );

    // behavioural slave: captures MOSI on its sampling edge, drives MISO from resp
    logic        slv_rst = 1'b0;
    int          cap_cnt = 0;
    logic [23:0] cap_word = '0;
    logic [23:0] resp = '0;
    int          cur_len = 8;

    function automatic int bpos(input int len, input int k, input bit lsb);
        return lsb ? k : (len - 1 - k);
    endfunction

    always @(posedge sclk or negedge sclk or posedge slv_rst) begin
        if (slv_rst) begin
            cap_cnt  = 0;
            cap_word = '0;
        end else if (sclk == !(cfg_cpol ^ cfg_cpha)) begin
            if (cap_cnt < cur_len)
                cap_word[bpos(cur_len, cap_cnt, cfg_lsb_first)] = mosi;
            cap_cnt = cap_cnt + 1;
        end
    end

    always_comb begin
        if (cap_cnt < cur_len)
            miso = resp[bpos(cur_len, cap_cnt, cfg_lsb_first)];
        else
            miso = 1'b0;
    end

    task automatic check_eq(input string req, input string what,
                            input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic push(input logic [23:0] d, input logic l);
        tx_data = d;
        tx_last = l;
        tx_push = 1'b1;
        step();
        tx_push = 1'b0;
        tx_last = 1'b0;
    endtask

    task automatic start_pulse();
        cmd_start = 1'b1;
        step();
        cmd_start = 1'b0;
    endtask

    task automatic pop(output logic [23:0] v);
        v = rx_data;
        rx_pop = 1'b1;
        step();
        rx_pop = 1'b0;
    endtask

    task automatic clear_events();
        evt_clear = 5'h1f;
        step();
        evt_clear = '0;
    endtask

    task automatic wait_ev(input int b, input string req);
        int t = 0;
        while (!evt_pending[b] && t < 5000) begin
            step();
            t++;
        end
        check_eq(req, "event wait", 32'(evt_pending[b]), 32'd1);
    endtask

    task automatic configure(input int len, input int mode, input bit lsb, input bit lb);
        cfg_word_len  = 5'(len);
        cur_len       = (len < 4) ? 4 : ((len > 24) ? 24 : len);
        cfg_cpol      = mode[1];
        cfg_cpha      = mode[0];
        cfg_lsb_first = lsb;
        cfg_loopback  = lb;
        repeat (3) step();
        slv_rst = 1'b1;
        step();
        slv_rst = 1'b0;
        step();
    endtask

    function automatic logic [23:0] lmask(input int len);
        return 24'((33'd1 << len) - 33'd1);
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        logic [23:0] d, r, v;
        logic [23:0] w [10];

        repeat (4) step();
        // reset state
        check_eq("R9", "dev_ready in reset", 32'(dev_ready), 32'd0);
        check_eq("R11", "pending in reset", 32'(evt_pending), 32'd0);
        check_eq("R12", "irq in reset", 32'(irq), 32'd0);
        check_eq("R7", "rx_empty in reset", 32'(rx_empty), 32'd1);
        check_eq("R7", "tx_full in reset", 32'(tx_full), 32'd0);
        check_eq("R8", "clear busy in reset", 32'({tx_clr_busy, rx_clr_busy}), 32'd0);
        rst = 1'b0;
        step();

        // enable -> ready one edge later
        cfg_enable = 1'b1;
        check_eq("R9", "ready before edge", 32'(dev_ready), 32'd0);
        step();
        check_eq("R9", "ready after enable", 32'(dev_ready), 32'd1);

        // idle clock level follows polarity
        cfg_cpol = 1'b1;
        step();
        check_eq("R3", "idle sclk cpol=1", 32'(sclk), 32'd1);
        cfg_cpol = 1'b0;
        step();
        check_eq("R3", "idle sclk cpol=0", 32'(sclk), 32'd0);

        // sweep: every length, mode and order against the slave model
        for (int l = 4; l <= 24; l++) begin
            for (int m = 0; m < 4; m++) begin
                for (int o = 0; o < 2; o++) begin
                    configure(l, m, o[0], 1'b0);
                    d = (24'h5C3A91 ^ 24'(l * 32'h1357) ^ 24'(m << 7) ^ 24'(o * 32'hF0F0F)) & lmask(l);
                    resp = (~d ^ 24'h2B6E19) & lmask(l);
                    push(d, 1'b1);
                    start_pulse();
                    wait_ev(0, "R4");
                    check_eq("R3", "sclk idle after word", 32'(sclk), 32'(m[1]));
                    check_eq("R1", "bit count", 32'(cap_cnt), 32'(l));
                    check_eq("R2", "mosi word", 32'(cap_word), 32'(d));
                    pop(v);
                    check_eq("R1", "rx word", 32'(v), 32'(resp));
                    clear_events();
                end
            end
        end

        // clamped length: 2 behaves as 4, 30 as 24
        configure(2, 0, 1'b0, 1'b0);
        resp = 24'h00000A;
        push(24'hFFFFF5, 1'b1);
        start_pulse();
        wait_ev(0, "R1");
        check_eq("R1", "clamp low count", 32'(cap_cnt), 32'd4);
        check_eq("R1", "clamp low mosi", 32'(cap_word), 32'h5);
        pop(v);
        check_eq("R1", "clamp low rx", 32'(v), 32'hA);
        clear_events();
        configure(30, 0, 1'b0, 1'b0);
        resp = 24'hC0FFEE;
        push(24'h123456, 1'b1);
        start_pulse();
        wait_ev(0, "R1");
        check_eq("R1", "clamp high count", 32'(cap_cnt), 32'd24);
        pop(v);
        check_eq("R1", "clamp high rx", 32'(v), 32'hC0FFEE);
        clear_events();

        // loopback, three words, last flag on the third
        configure(8, 1, 1'b0, 1'b1);
        resp = 24'hFF;
        for (int i = 0; i < 3; i++) w[i] = 24'(8'h3C + 8'(i * 37));
        push(w[0], 1'b0);
        push(w[1], 1'b0);
        push(w[2], 1'b1);
        start_pulse();
        wait_ev(0, "R4");
        check_eq("R4", "no underflow in chained run", 32'(evt_pending[1]), 32'd0);
        for (int i = 0; i < 3; i++) begin
            pop(v);
            check_eq("R10", "loopback word", 32'(v), 32'(w[i]));
        end
        check_eq("R4", "rx empty after 3", 32'(rx_empty), 32'd1);
        clear_events();

        // underflow pause and resume
        configure(12, 2, 1'b1, 1'b1);
        push(24'hABC, 1'b0);
        start_pulse();
        wait_ev(1, "R5");
        check_eq("R5", "no done on underflow", 32'(evt_pending[0]), 32'd0);
        repeat (10) step();
        check_eq("R5", "sclk parked", 32'(sclk), 32'd1);
        check_eq("R5", "one word received", 32'(rx_empty), 32'd0);
        clear_events();
        push(24'h5A3, 1'b1);
        start_pulse();
        wait_ev(0, "R5");
        pop(v);
        check_eq("R5", "first word", 32'(v), 32'hABC);
        pop(v);
        check_eq("R5", "resumed word", 32'(v), 32'h5A3);
        clear_events();

        // start with empty queue -> underflow
        start_pulse();
        step();
        check_eq("R5", "start on empty queue", 32'(evt_pending[1]), 32'd1);
        clear_events();

        // receive overflow: nine words, no pops
        configure(6, 0, 1'b0, 1'b1);
        for (int i = 0; i < 9; i++) w[i] = 24'(i * 7 + 3) & lmask(6);
        for (int i = 0; i < 8; i++) push(w[i], 1'b0);
        check_eq("R7", "tx full after 8", 32'(tx_full), 32'd1);
        start_pulse();
        while (tx_full) step();
        push(w[8], 1'b1);
        wait_ev(0, "R6");
        check_eq("R6", "overflow event", 32'(evt_pending[2]), 32'd1);
        for (int i = 0; i < 8; i++) begin
            pop(v);
            check_eq("R6", "kept word", 32'(v), 32'(w[i]));
        end
        check_eq("R6", "ninth dropped", 32'(rx_empty), 32'd1);
        clear_events();

        // push into full queue ignored, pop from empty ignored
        configure(5, 3, 1'b1, 1'b1);
        pop(v);
        for (int i = 0; i < 8; i++) push(24'(i + 9) & lmask(5), (i == 7) ? 1'b1 : 1'b0);
        push(24'h1F, 1'b0);
        start_pulse();
        wait_ev(0, "R7");
        for (int i = 0; i < 8; i++) begin
            pop(v);
            check_eq("R7", "queued word", 32'(v), 32'(i + 9));
        end
        check_eq("R7", "extra push ignored", 32'(rx_empty), 32'd1);
        clear_events();

        // transmit clear
        push(24'h11, 1'b1);
        push(24'h22, 1'b1);
        cmd_clr_tx = 1'b1;
        step();
        cmd_clr_tx = 1'b0;
        check_eq("R8", "tx busy set", 32'(tx_clr_busy), 32'd1);
        step();
        check_eq("R8", "tx busy cleared", 32'(tx_clr_busy), 32'd0);
        clear_events();
        start_pulse();
        step();
        check_eq("R8", "tx queue empty after clear", 32'(evt_pending[1]), 32'd1);
        check_eq("R8", "no done after clear", 32'(evt_pending[0]), 32'd0);
        clear_events();

        // receive clear
        push(24'h07, 1'b0);
        push(24'h19, 1'b1);
        start_pulse();
        wait_ev(0, "R8");
        check_eq("R8", "rx has data", 32'(rx_empty), 32'd0);
        cmd_clr_rx = 1'b1;
        step();
        cmd_clr_rx = 1'b0;
        check_eq("R8", "rx busy set", 32'(rx_clr_busy), 32'd1);
        step();
        check_eq("R8", "rx busy cleared", 32'(rx_clr_busy), 32'd0);
        check_eq("R8", "rx empty after clear", 32'(rx_empty), 32'd1);
        clear_events();

        // events and interrupt
        check_eq("R11", "tx request re-asserts", 32'(evt_pending[3]), 32'd1);
        check_eq("R11", "done cleared", 32'(evt_pending[0]), 32'd0);
        check_eq("R12", "all masked", 32'(irq), 32'd0);
        evt_mask = 5'b10111;
        #0;
        step();
        check_eq("R12", "tx request unmasked", 32'(irq), 32'd1);
        evt_mask = 5'b11110;
        push(24'h0F, 1'b1);
        start_pulse();
        check_eq("R12", "done not yet", 32'(irq), 32'd0);
        wait_ev(0, "R12");
        check_eq("R12", "irq on done", 32'(irq), 32'd1);
        evt_clear = 5'b00001;
        step();
        evt_clear = '0;
        check_eq("R11", "w1c done", 32'(evt_pending[0]), 32'd0);
        check_eq("R12", "irq drops", 32'(irq), 32'd0);
        check_eq("R11", "rx request pending", 32'(evt_pending[4]), 32'd1);
        pop(v);
        evt_mask = 5'h1f;
        clear_events();

        // disabled engine ignores start
        cfg_enable = 1'b0;
        push(24'h15, 1'b1);
        step();
        check_eq("R9", "ready drops", 32'(dev_ready), 32'd0);
        start_pulse();
        repeat (30) step();
        check_eq("R9", "no done when disabled", 32'(evt_pending[0]), 32'd0);
        check_eq("R9", "sclk idle when disabled", 32'(sclk), 32'(cfg_cpol));
        cfg_enable = 1'b1;
        step();
        start_pulse();
        wait_ev(0, "R9");
        pop(v);
        check_eq("R9", "word sent after enable", 32'(v), 32'h15);

        finished = 1'b1;
        $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule